// File: doc/BRIEF.md
# Synthesizer Power-Down and Counter-Reset Sequencer

This block turns a hardware chip-enable pin and three programmed control bits into the hold, tristate, reset and enable signals that the rest of a frequency synthesizer obeys. It owns the function word of the programming interface. A word is taken into the function word only when its two low address bits are both 1. Three fields of that word matter here:

- a power-down request bit;
- a mode bit that picks immediate or pump-gated power-down;
- a counter-reset bit.

In immediate mode, requesting power-down takes effect on the clock edge that stores the word. In pump-gated mode, the request is armed first. The block then waits for the next charge-pump event, a one-cycle pulse that marks the end of an up or down pump pulse, so that the loop is not disturbed mid-correction. The pin overrides everything: when it is low, the outputs show power-down in the same cycle. The programming register accepts words at all times, including during power-down. Analog biasing is represented only by the buffer-enable outputs.

Top module: `pd_sequencer`

## Requirements
- R1: While `chip_en` is low, `powered_down`, `pump_tristate`, `clkdet_rst` and all three counter holds are 1, and both buffer enables are 0, in the same cycle, whatever the stored bits.
- R2: A function load (`prog_load`=1, `prog_word[1:0]`=2'b11) with bit 3 (power-down request) = 1 and bit 21 (mode) = 0 makes `powered_down` 1 from the cycle after the load edge.
- R3: A function load with bit 3 = 1 and bit 21 = 1 raises `pd_armed` without powering down. Power-down starts on the first edge at which `pump_evt` is sampled high; this includes the load edge itself.
- R4: During power-down, `ref_cnt_hold`, `fb_cnt_hold` and `tmo_cnt_hold` are 1 and `pump_tristate` is 1.
- R5: During power-down, `clkdet_rst` is 1 and both `rf_buf_en` and `ref_buf_en` are 0.
- R6: Every function load stores the whole word in `fl_word` on its edge, also during power-down. A load whose `prog_word[1:0]` is not 2'b11 changes neither `fl_word` nor any output.
- R7: With stored bit 2 (counter reset) = 1, `ref_cnt_hold` and `fb_cnt_hold` are 1. `tmo_cnt_hold` stays 0 unless the block is powered down.
- R8: A function load with bit 3 = 0 clears `pd_armed` and cancels a pending power-down, even when `pump_evt` is high on the same edge.
- R9: When `chip_en` is high and the stored bit 3 is 0, every hold, tristate and reset output is 0 and both buffer enables are 1 in the same cycle, apart from the counter-reset holds of R7.
- R10: After reset, `fl_word` is 0, `pd_armed` is 0 and, with `chip_en` high, `powered_down` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Hardware enable pin; low forces power-down |
| prog_load | input | 1 | Strobe that presents `prog_word` for latching |
| prog_word | input | 24 | Programming word; bits [1:0] select the target |
| pump_evt | input | 1 | One-cycle pulse at the end of a charge-pump pulse |
| fl_word | output | 24 | Stored function word |
| powered_down | output | 1 | Block is in power-down (pin or programmed) |
| pd_armed | output | 1 | Pump-gated power-down is waiting for a pump event |
| ref_cnt_hold | output | 1 | Hold reference counter at its load value |
| fb_cnt_hold | output | 1 | Hold A/B feedback counters at their load values |
| tmo_cnt_hold | output | 1 | Hold fast-lock timeout counter at its load value |
| pump_tristate | output | 1 | Force charge-pump output to high impedance |
| clkdet_rst | output | 1 | Reset clock-detect logic |
| rf_buf_en | output | 1 | RF input buffer enable |
| ref_buf_en | output | 1 | Reference input buffer enable |

## Verification
Two things can fall in the same cycle: a function load that changes the power-down request, and a charge-pump event. A load that arms pump-gated mode, presented together with a pump pulse, must power down on that edge. A load that clears the request together with a pump pulse must leave the block running with `pd_armed` low. The bench provokes both collisions directly and also lets random loads and pump pulses overlap freely. Each cycle is judged against a bench model that updates its stored bits first and then applies the pump event.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
    localparam int WORD_W    = 24;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] FUNC_ADDR = 2'b11;
    localparam int PDREQ_POS = 3;
    localparam int MODE_POS  = 21;
    localparam int CRST_POS  = 2;

    typedef enum logic [1:0] {
        PD_RUN   = 2'b00,
        PD_ARMED = 2'b01,
        PD_DOWN  = 2'b10
    } pd_state_e;

    typedef struct packed {
        logic req;
        logic sync_mode;
        logic cnt_rst;
    } func_bits_t;
endpackage

// File: rtl/pd_func_latch.sv
module pd_func_latch
    import pd_seq_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic [W-1:0] word_q_o,
    output func_bits_t   bits_q_o,
    output func_bits_t   bits_nx_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } latch_t;

    latch_t s_d, s_q;
    logic   hit;

    always_comb begin
        s_d = s_q;
        hit = load && (word[ADDR_W-1:0] == FUNC_ADDR);
        if (hit) s_d.word = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_q_o            = s_q.word;
    assign bits_q_o.req        = s_q.word[PDREQ_POS];
    assign bits_q_o.sync_mode  = s_q.word[MODE_POS];
    assign bits_q_o.cnt_rst    = s_q.word[CRST_POS];
    assign bits_nx_o.req       = s_d.word[PDREQ_POS];
    assign bits_nx_o.sync_mode = s_d.word[MODE_POS];
    assign bits_nx_o.cnt_rst   = s_d.word[CRST_POS];

    // R6
    store_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[ADDR_W-1:0] == FUNC_ADDR) |=> (word_q_o == $past(word)));

    // R6
    other_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load || word[ADDR_W-1:0] != FUNC_ADDR) |=> $stable(word_q_o));
endmodule

// File: rtl/pd_state_ctl.sv
module pd_state_ctl
    import pd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  func_bits_t bits_nx,
    input  logic       pump_evt,
    output logic       armed_o,
    output logic       down_o
);
    typedef struct packed {
        pd_state_e st;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!bits_nx.req) begin
            s_d.st = PD_RUN;
        end else if (!bits_nx.sync_mode) begin
            s_d.st = PD_DOWN;
        end else if (s_q.st == PD_DOWN || pump_evt) begin
            s_d.st = PD_DOWN;
        end else begin
            s_d.st = PD_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PD_RUN};
        else        s_q <= s_d;
    end

    assign armed_o = (s_q.st == PD_ARMED);
    assign down_o  = (s_q.st == PD_DOWN);

    // R3
    armed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && down_o));

    // R8
    cancel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bits_nx.req) |=> (!armed_o && !down_o));
endmodule

// File: rtl/pd_out_drv.sv
module pd_out_drv
    import pd_seq_pkg::*;
#(
    parameter int N_CNT = 3
) (
    input  logic             chip_en,
    input  logic             prog_down,
    input  func_bits_t       bits_q,
    output logic             pd_o,
    output logic [N_CNT-1:0] hold_o,
    output logic             tri_o,
    output logic             det_rst_o,
    output logic             rf_en_o,
    output logic             ref_en_o
);
    localparam int TMO_IDX = N_CNT - 1;

    logic pd_c;

    always_comb begin
        pd_c      = !chip_en || prog_down;
        tri_o     = pd_c;
        det_rst_o = pd_c;
        rf_en_o   = !pd_c;
        ref_en_o  = !pd_c;
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_hold
        if (i == TMO_IDX) begin : g_tmo
            assign hold_o[i] = pd_c;
        end else begin : g_div
            assign hold_o[i] = pd_c || bits_q.cnt_rst;
        end
    end

    assign pd_o = pd_c;
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pd_seq_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chip_en,
    input  logic         prog_load,
    input  logic [W-1:0] prog_word,
    input  logic         pump_evt,
    output logic [W-1:0] fl_word,
    output logic         powered_down,
    output logic         pd_armed,
    output logic         ref_cnt_hold,
    output logic         fb_cnt_hold,
    output logic         tmo_cnt_hold,
    output logic         pump_tristate,
    output logic         clkdet_rst,
    output logic         rf_buf_en,
    output logic         ref_buf_en
);
    localparam int N_CNT = 3;

    func_bits_t       bits_q, bits_nx;
    logic             prog_down;
    logic [N_CNT-1:0] holds;

    pd_func_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(prog_load), .word(prog_word),
        .word_q_o(fl_word), .bits_q_o(bits_q), .bits_nx_o(bits_nx)
    );

    pd_state_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .bits_nx(bits_nx), .pump_evt(pump_evt),
        .armed_o(pd_armed), .down_o(prog_down)
    );

    pd_out_drv #(.N_CNT(N_CNT)) u_drv (
        .chip_en(chip_en), .prog_down(prog_down), .bits_q(bits_q),
        .pd_o(powered_down), .hold_o(holds), .tri_o(pump_tristate),
        .det_rst_o(clkdet_rst), .rf_en_o(rf_buf_en), .ref_en_o(ref_buf_en)
    );

    assign ref_cnt_hold = holds[0];
    assign fb_cnt_hold  = holds[1];
    assign tmo_cnt_hold = holds[2];

    // R1
    pin_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (pump_tristate && clkdet_rst && tmo_cnt_hold && !rf_buf_en && !ref_buf_en));

    // R2
    async_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_load && prog_word[1:0] == FUNC_ADDR && prog_word[PDREQ_POS] && !prog_word[MODE_POS])
        |=> powered_down);

    // R3
    pump_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_armed && pump_evt && !prog_load) |=> powered_down);

    // R3
    armed_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_armed && !pump_evt && !prog_load) |=> (pd_armed && (!powered_down || !chip_en)));

    // R4
    pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |-> (ref_cnt_hold && fb_cnt_hold && tmo_cnt_hold && pump_tristate));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !fl_word[PDREQ_POS]) |-> (!powered_down && rf_buf_en && !tmo_cnt_hold));
endmodule

// File: tb/sim_pd_sequencer.sv
`timescale 1ns/1ps
module sim_pd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b1;
    logic        prog_load = 1'b0;
    logic [23:0] prog_word = '0;
    logic        pump_evt = 1'b0;
    logic [23:0] fl_word;
    logic        powered_down, pd_armed, ref_cnt_hold, fb_cnt_hold, tmo_cnt_hold;
    logic        pump_tristate, clkdet_rst, rf_buf_en, ref_buf_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model: 0 run, 1 armed, 2 down
    logic [23:0] m_word = '0;
    int          m_st = 0;

    always #2 clk = ~clk;

    pd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .prog_load(prog_load),
        .prog_word(prog_word), .pump_evt(pump_evt), .fl_word(fl_word),
        .powered_down(powered_down), .pd_armed(pd_armed), .ref_cnt_hold(ref_cnt_hold),
        .fb_cnt_hold(fb_cnt_hold), .tmo_cnt_hold(tmo_cnt_hold),
        .pump_tristate(pump_tristate), .clkdet_rst(clkdet_rst),
        .rf_buf_en(rf_buf_en), .ref_buf_en(ref_buf_en)
    );

    function automatic logic [23:0] fword(bit req, bit mode, bit crst, logic [23:0] rest);
        logic [23:0] w = rest;
        w[1:0] = 2'b11; w[3] = req; w[21] = mode; w[2] = crst;
        return w;
    endfunction

    function automatic int next_st(int st, logic [23:0] w, bit pe);
        if (!w[3]) return 0;
        if (!w[21]) return 2;
        if (st == 2 || pe) return 2;
        return 1;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        bit pd = !chip_en || (m_st == 2);
        string t = !chip_en ? "R1" : (m_st == 2 ? "R2/R3 state" : "R9");
        chk({31'd0, powered_down}, {31'd0, pd}, t);
        chk({31'd0, pd_armed}, {31'd0, m_st == 1}, "R3 armed");
        chk({31'd0, ref_cnt_hold}, {31'd0, pd || m_word[2]}, "R4 R7 ref hold");
        chk({31'd0, fb_cnt_hold}, {31'd0, pd || m_word[2]}, "R4 R7 fb hold");
        chk({31'd0, tmo_cnt_hold}, {31'd0, pd}, "R4 R7 tmo hold");
        chk({31'd0, pump_tristate}, {31'd0, pd}, "R4 tristate");
        chk({31'd0, clkdet_rst}, {31'd0, pd}, "R5 clkdet");
        chk({30'd0, rf_buf_en, ref_buf_en}, {30'd0, !pd, !pd}, "R5 buffers");
        chk({8'd0, fl_word}, {8'd0, m_word}, "R6 word");
    endtask

    // drive at negedge, model at posedge, check at next negedge
    task automatic cyc(bit ce, bit ld, logic [23:0] w, bit pe);
        chip_en = ce; prog_load = ld; prog_word = w; pump_evt = pe;
        @(posedge clk);
        if (ld && w[1:0] == 2'b11) m_word = w;
        m_st = next_st(m_st, m_word, pe);
        @(negedge clk);
        prog_load = 1'b0; pump_evt = 1'b0;
        check_all();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({8'd0, fl_word}, 24'd0, "R10 word");
        chk({30'd0, powered_down, pd_armed}, 32'd0, "R10 pd");
        check_all();

        // R2 immediate power-down, then R9 release
        cyc(1, 1, fword(1, 0, 0, 24'h0), 0);
        chk({31'd0, powered_down}, 32'd1, "R2 immediate");
        cyc(1, 1, fword(0, 0, 0, 24'h0), 0);
        chk({31'd0, powered_down}, 32'd0, "R9 release");

        // R3 armed then pump
        cyc(1, 1, fword(1, 1, 0, 24'h0), 0);
        chk({31'd0, pd_armed}, 32'd1, "R3 armed");
        cyc(1, 0, 24'h0, 0);
        chk({31'd0, powered_down}, 32'd0, "R3 waits");
        cyc(1, 0, 24'h0, 1);
        chk({31'd0, powered_down}, 32'd1, "R3 pump fires");
        // R6 load during power-down
        cyc(1, 1, fword(1, 1, 0, 24'h5A0000), 0);
        chk({8'd0, fl_word}, {8'd0, fword(1, 1, 0, 24'h5A0000)}, "R6 load in pd");

        // R8 cancel with pump on same edge
        cyc(1, 1, fword(0, 0, 0, 24'h0), 0);
        cyc(1, 1, fword(1, 1, 0, 24'h0), 0);
        cyc(1, 1, fword(0, 1, 0, 24'h0), 1);
        chk({30'd0, powered_down, pd_armed}, 32'd0, "R8 cancel collision");

        // R3 arm and pump on load edge
        cyc(1, 1, fword(1, 1, 0, 24'h0), 1);
        chk({31'd0, powered_down}, 32'd1, "R3 load+pump collision");
        cyc(1, 1, fword(0, 0, 0, 24'h0), 0);

        // R6 other address ignored
        cyc(1, 1, 24'hFFFFF8 | 24'h1, 0);
        chk({31'd0, powered_down}, 32'd0, "R6 other addr no pd");
        chk({8'd0, fl_word}, {8'd0, fword(0, 0, 0, 24'h0)}, "R6 other addr word");

        // R7 counter reset
        cyc(1, 1, fword(0, 0, 1, 24'h0), 0);
        chk({29'd0, ref_cnt_hold, fb_cnt_hold, tmo_cnt_hold}, 32'b110, "R7 crst");
        cyc(1, 1, fword(0, 0, 0, 24'h0), 0);

        // R1 pin low with nothing programmed
        cyc(0, 0, 24'h0, 0);
        chk({31'd0, pump_tristate}, 32'd1, "R1 pin low");
        cyc(1, 0, 24'h0, 0);
        chk({31'd0, rf_buf_en}, 32'd1, "R9 pin high");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit ce = ($urandom % 8) != 0;
            bit ld = ($urandom % 3) == 0;
            logic [23:0] w = 24'($urandom);
            bit pe = ($urandom % 4) == 0;
            if (($urandom % 4) != 0) w[1:0] = 2'b11;
            cyc(ce, ld, w, pe);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule